// File: doc/BRIEF.md
# Shared Multi-Port VLIW Register File

This block is the architectural register storage for a wide-issue datapath in which several execution lanes work in parallel on one common set of registers. Every lane owns two read ports and one write port. A lane reads its two operands with no clock delay and writes one result at the clock edge. Each register picks its incoming value through its own lane-select multiplexer and its own enable, so any lane can write any register.

A combinational accelerator attached beside the lanes needs no bus. It sees every register at once on a wide view port. It can overwrite any subset of registers in a cycle through a per-register enable mask, and a mask write takes priority over lane writes. Register 0 is hardwired to zero. When two lanes aim at the same register in one cycle, a fixed priority picks the winner and a conflict flag is raised for that cycle.

Top module: `vliw_shared_rf`

## Requirements
- R1: While `rst_n` is low, every register is cleared. After reset, every read port and every slice of `fn_view` returns zero until a write happens.
- R2: Register 0 always reads as zero on every read port and on `fn_view` bits [W-1:0]. Lane writes and mask writes aimed at it have no effect.
- R3: There are 2×LANES read ports. Port p takes its address from `rd_addr[p*AW +: AW]` and returns that register's value on `rd_data[p*W +: W]` with no clock delay. Each port is independent of the others.
- R4: A lane l with `lane_we[l]` high writes `lane_wdata[l*W +: W]` into register `lane_waddr[l*AW +: AW]` on the rising clock edge. The new value can be read from the following cycle onward.
- R5: A read of a register that is being written in the same cycle returns the value held before the edge. There is no write-to-read bypass.
- R6: When several enabled lanes address the same register, the lane with the highest index decides the stored value.
- R7: `wr_conflict` is high, combinationally, in a cycle where two or more enabled lanes address the same non-zero register. It is low otherwise, including when the only shared target is register 0.
- R8: When bit r of `fn_we` is high, register r takes `fn_wdata[r*W +: W]` at the edge. This overrides every lane write to register r in that cycle.
- R9: `fn_view[r*W +: W]` always shows the current contents of register r, for every r.
- R10: A register that is addressed by no enabled lane and has its `fn_we` bit low keeps its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous clear |
| lane_we | input | LANES | Per-lane write enable |
| lane_waddr | input | LANES*AW | Per-lane write register index, lane l at l*AW |
| lane_wdata | input | LANES*W | Per-lane write data, lane l at l*W |
| rd_addr | input | 2*LANES*AW | Read indices, port p at p*AW |
| rd_data | output | 2*LANES*W | Read data, port p at p*W |
| fn_we | input | NREG | Accelerator per-register write mask |
| fn_wdata | input | NREG*W | Accelerator write values, register r at r*W |
| fn_view | output | NREG*W | All register contents, register r at r*W |
| wr_conflict | output | 1 | Two or more lanes hit one non-zero register this cycle |

## Verification
The assertions assume that the inputs are stable at the rising edge and carry no unknown values once reset is released. The bench therefore sets every input on the falling edge and drives all inputs to defined values before reset ends. The random phase sometimes narrows lane addresses to a few registers, register 0 included, so that lane collisions and zero-register writes happen often. It keeps the accelerator mask sparse, so lane writes usually decide a register's value. Directed cycles then force a four-way collision, a mask write that collides with a lane write, and writes to register 0.

// File: rtl/vliw_shared_rf.sv
module vliw_shared_rf #(
  parameter int LANES = 4,
  parameter int NREG  = 32,
  parameter int W     = 32,
  localparam int AW   = $clog2(NREG),
  localparam int RP   = 2 * LANES
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [LANES-1:0]    lane_we,
  input  logic [LANES*AW-1:0] lane_waddr,
  input  logic [LANES*W-1:0]  lane_wdata,
  input  logic [RP*AW-1:0]    rd_addr,
  output logic [RP*W-1:0]     rd_data,
  input  logic [NREG-1:0]     fn_we,
  input  logic [NREG*W-1:0]   fn_wdata,
  output logic [NREG*W-1:0]   fn_view,
  output logic                wr_conflict
);

  logic [W-1:0] regs [NREG];
  logic [W-1:0] nxt  [NREG];
  logic [NREG-1:0] upd;

  always_comb begin
    for (int r = 0; r < NREG; r++) begin
      upd[r] = 1'b0;
      nxt[r] = regs[r];
      for (int l = 0; l < LANES; l++)
        if (lane_we[l] && lane_waddr[l*AW +: AW] == AW'(r)) begin
          upd[r] = 1'b1;
          nxt[r] = lane_wdata[l*W +: W];
        end
      if (fn_we[r]) begin
        upd[r] = 1'b1;
        nxt[r] = fn_wdata[r*W +: W];
      end
      if (r == 0) upd[r] = 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int r = 0; r < NREG; r++) regs[r] <= '0;
    end else begin
      for (int r = 0; r < NREG; r++)
        if (upd[r]) regs[r] <= nxt[r];
    end
  end

  genvar gp, gr;
  generate
    for (gp = 0; gp < RP; gp++) begin : g_rd
      wire [AW-1:0] a = rd_addr[gp*AW +: AW];
      assign rd_data[gp*W +: W] = (a == '0) ? '0 : regs[a];
    end
    for (gr = 0; gr < NREG; gr++) begin : g_view
      if (gr == 0) begin : g_z
        assign fn_view[W-1:0] = '0;
      end else begin : g_v
        assign fn_view[gr*W +: W] = regs[gr];
      end
    end
  endgenerate

  always_comb begin
    wr_conflict = 1'b0;
    for (int i = 0; i < LANES; i++)
      for (int j = i + 1; j < LANES; j++)
        if (lane_we[i] && lane_we[j] &&
            lane_waddr[i*AW +: AW] == lane_waddr[j*AW +: AW] &&
            lane_waddr[i*AW +: AW] != '0)
          wr_conflict = 1'b1;
  end

  // assertion helpers, built from ports only
  logic [NREG-1:0]  hit;
  logic [LANES-1:0] wins;
  always_comb begin
    hit = '0;
    for (int l = 0; l < LANES; l++)
      if (lane_we[l]) hit[lane_waddr[l*AW +: AW]] = 1'b1;
    for (int l = 0; l < LANES; l++) begin
      wins[l] = lane_we[l] && !fn_we[lane_waddr[l*AW +: AW]];
      for (int k = l + 1; k < LANES; k++)
        if (lane_we[k] && lane_waddr[k*AW +: AW] == lane_waddr[l*AW +: AW])
          wins[l] = 1'b0;
    end
  end

  a_r2_zero_reg: assert property (@(posedge clk) disable iff (!rst_n)
    fn_view[W-1:0] == '0);

  a_r7_conflict_needs_two: assert property (@(posedge clk) disable iff (!rst_n)
    wr_conflict |-> $countones(lane_we) >= 2);

  generate
    for (gp = 0; gp < LANES; gp++) begin : g_la
      a_r6_lane_win: assert property (@(posedge clk) disable iff (!rst_n)
        (wins[gp] && lane_waddr[gp*AW +: AW] != '0) |=>
        fn_view[$past(lane_waddr[gp*AW +: AW])*W +: W] == $past(lane_wdata[gp*W +: W]));
    end
    for (gr = 1; gr < NREG; gr++) begin : g_ra
      a_r8_fn_prio: assert property (@(posedge clk) disable iff (!rst_n)
        fn_we[gr] |=> fn_view[gr*W +: W] == $past(fn_wdata[gr*W +: W]));
      a_r10_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!fn_we[gr] && !hit[gr]) |=> $stable(fn_view[gr*W +: W]));
    end
  endgenerate

endmodule

// File: tb/vliw_shared_rf_tb.sv
`timescale 1ns/1ps
module vliw_shared_rf_tb;
  localparam int LANES = 4, NREG = 32, W = 32, AW = 5, RP = 8;

  logic clk = 0, rst_n = 0;
  logic [LANES-1:0]    lane_we = '0;
  logic [LANES*AW-1:0] lane_waddr = '0;
  logic [LANES*W-1:0]  lane_wdata = '0;
  logic [RP*AW-1:0]    rd_addr = '0;
  logic [RP*W-1:0]     rd_data;
  logic [NREG-1:0]     fn_we = '0;
  logic [NREG*W-1:0]   fn_wdata = '0;
  logic [NREG*W-1:0]   fn_view;
  logic                wr_conflict;

  int n_chk = 0, n_bad = 0;
  logic [W-1:0] model [NREG];

  always #2.5 clk = ~clk;

  vliw_shared_rf u_dut (.clk(clk), .rst_n(rst_n), .lane_we(lane_we),
    .lane_waddr(lane_waddr), .lane_wdata(lane_wdata), .rd_addr(rd_addr),
    .rd_data(rd_data), .fn_we(fn_we), .fn_wdata(fn_wdata),
    .fn_view(fn_view), .wr_conflict(wr_conflict));

  task automatic chk(string req, logic [W-1:0] act, logic [W-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic exp_conflict();
    for (int i = 0; i < LANES; i++)
      for (int j = i + 1; j < LANES; j++)
        if (lane_we[i] && lane_we[j] && lane_waddr[i*AW +: AW] == lane_waddr[j*AW +: AW]
            && lane_waddr[i*AW +: AW] != 0) return 1'b1;
    return 1'b0;
  endfunction

  task automatic model_step();
    for (int r = 1; r < NREG; r++) begin
      for (int l = 0; l < LANES; l++)
        if (lane_we[l] && lane_waddr[l*AW +: AW] == AW'(r)) model[r] = lane_wdata[l*W +: W];
      if (fn_we[r]) model[r] = fn_wdata[r*W +: W];
    end
  endtask

  // called just after a falling edge with inputs set; returns at next falling edge
  task automatic cycle();
    #1;
    for (int p = 0; p < RP; p++) begin
      int a = int'(rd_addr[p*AW +: AW]);
      chk("R3/R5 read", rd_data[p*W +: W], a == 0 ? '0 : model[a]);
    end
    chk("R7 conflict", {31'b0, wr_conflict}, {31'b0, exp_conflict()});
    @(posedge clk);
    model_step();
    @(negedge clk);
    for (int r = 0; r < NREG; r++)
      chk("R9/R4/R6/R8/R10/R2 view", fn_view[r*W +: W], r == 0 ? '0 : model[r]);
  endtask

  task automatic idle();
    lane_we = '0; fn_we = '0;
  endtask

  initial begin
    #150000;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    void'($urandom(32'h5eed_1234));
    for (int r = 0; r < NREG; r++) model[r] = '0;
    lane_wdata = {LANES{32'hdead_beef}};
    fn_wdata = {NREG{32'hcafe_f00d}};
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R1: cleared after reset
    for (int r = 0; r < NREG; r++) chk("R1 reset view", fn_view[r*W +: W], '0);
    for (int p = 0; p < RP; p++) rd_addr[p*AW +: AW] = AW'(p * 3 + 1);
    #1;
    for (int p = 0; p < RP; p++) chk("R1 reset read", rd_data[p*W +: W], '0);
    @(negedge clk);

    // R4/R5: write then read same register in same cycle and next
    idle();
    lane_we = 4'b0001; lane_waddr[0 +: AW] = 5'd7; lane_wdata[0 +: W] = 32'h1111_2222;
    rd_addr[0 +: AW] = 5'd7;
    cycle();
    idle(); cycle();
    chk("R4 next-cycle read", rd_data[0 +: W], 32'h1111_2222);

    // R6/R7: all four lanes hit register 9
    lane_we = 4'b1111;
    for (int l = 0; l < LANES; l++) begin
      lane_waddr[l*AW +: AW] = 5'd9;
      lane_wdata[l*W +: W] = 32'h9000_0000 + l;
    end
    cycle();
    chk("R6 top lane wins", fn_view[9*W +: W], 32'h9000_0003);

    // R7: collision on register 0 only is not a conflict; R2 ignores the writes
    for (int l = 0; l < LANES; l++) lane_waddr[l*AW +: AW] = 5'd0;
    fn_we = 32'h0000_0001; fn_wdata[0 +: W] = 32'hffff_ffff;
    rd_addr[W/W*0 +: AW] = 5'd0;
    cycle();
    chk("R2 zero register view", fn_view[0 +: W], '0);
    chk("R2 zero register read", rd_data[0 +: W], '0);

    // R8: mask write beats lane write on register 12
    idle();
    lane_we = 4'b1000; lane_waddr[3*AW +: AW] = 5'd12; lane_wdata[3*W +: W] = 32'haaaa_aaaa;
    fn_we = 32'h0000_1000; fn_wdata[12*W +: W] = 32'h5555_0012;
    cycle();
    chk("R8 mask priority", fn_view[12*W +: W], 32'h5555_0012);
    idle();

    // random phase
    for (int it = 0; it < 3000; it++) begin
      bit narrow = ($urandom % 3) == 0;
      lane_we = LANES'($urandom);
      for (int l = 0; l < LANES; l++) begin
        lane_waddr[l*AW +: AW] = narrow ? AW'($urandom % 3) : AW'($urandom);
        lane_wdata[l*W +: W] = $urandom;
      end
      for (int p = 0; p < RP; p++) rd_addr[p*AW +: AW] = AW'($urandom);
      for (int r = 0; r < NREG; r++) begin
        fn_we[r] = ($urandom % 16) == 0;
        fn_wdata[r*W +: W] = $urandom;
      end
      cycle();
    end
    idle();

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule